// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block is the synchronous control front end of a burst SRAM together with a behavioural storage array. At every rising clock edge it samples two address strobes (a processor-side strobe and a controller-side strobe), a burst-advance input, two chip enables and the write controls. From these it decides whether the cycle is a read, a per-byte write or a deselect. It then either loads a new word address or steps a 2-bit burst counter that supplies the two low address bits, in linear or interleaved order.

Read data leaves the block either straight from the array (flow-through) or through one more output register (pipeline). A drive-enable output stands in for the tri-state data pins. Deselects pass through the same output pipeline as reads, so the drivers turn off one cycle later than the deselect command (dual-cycle deselect). An asynchronous output-enable input can force the drivers off at any moment.

Top module: `sbsram_ctrl`

## Requirements
- R1: With `burst_il` low, a burst loaded at address A visits A, then A with low two bits (A[1:0]+1) mod 4, +2, +3; the bits above bit 1 stay as loaded.
- R2: With `burst_il` high, the k-th step of a burst uses low bits A[1:0] XOR k.
- R3: The fifth access of a burst that advanced four times returns to the loaded start address.
- R4: With neither strobe accepted and `adv_n` high, an active burst repeats the address of the previous cycle.
- R5: When `en1_n` is high, `strb_cpu_n` low is ignored, so the cycle continues or suspends the burst. `strb_ctl_n` low with `en1_n` high is a deselect.
- R6: When a strobe is accepted and `en2` is low, the cycle is a deselect: no byte of the array is written.
- R7: `wr_all_n` low writes all bytes. Otherwise `wr_bytes_n` low writes each byte i whose `byte_en_n[i]` is low (byte i is `din[8i+7:8i]`). With no byte enable low, or with `wr_bytes_n` high, the cycle is a read.
- R8: A cycle started by `strb_cpu_n` is always a read, whatever the write inputs are.
- R9: With `pipe_en` low, data read at edge E is on `dout` with `dout_oe` high right after E. With `pipe_en` high, it appears right after edge E+1.
- R10: After a read, a deselect taken at edge E leaves the drivers on until edge E+1 and turns them off after E+1, in both output modes.
- R11: `dout_oe` is low during the cycle after an edge that performed a write.
- R12: `out_en_n` high forces `dout_oe` low at once. Reads issued while it is high still step the burst counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | External word address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low, read only |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | First chip enable, active low |
| en2 | input | 1 | Second chip enable, active high, used only with a strobe |
| wr_all_n | input | 1 | Write every byte, active low |
| wr_bytes_n | input | 1 | Byte-write qualifier, active low |
| byte_en_n | input | BYTES | Per-byte write enables, active low |
| burst_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| pipe_en | input | 1 | Output mode: 0 flow-through, 1 pipeline |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | BYTES*BYTE_W | Write data |
| dout | output | BYTES*BYTE_W | Read data |
| dout_oe | output | 1 | Data driver enable (low means high impedance) |

## Verification
The assertions check on every cycle that output enable high keeps the drivers off, that a controller-started write leaves them off in the next cycle, and that in pipeline mode a deselect (from `en1_n` or `en2`) turns them off after the following edge. They also check that a processor-started read drives in flow-through mode. Address order, wrap, suspend, byte merging, ignored writes and dummy-read counting depend on stored data. Only the bench scenarios can show these, by reading back values written earlier, and they also time the flow-through deselect hold.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // Low two address bits for burst step cnt from start
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       il);
        return il ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             en1_n,
    input  logic             en2,
    input  logic             wr_all_n,
    input  logic             wr_bytes_n,
    input  logic [BYTES-1:0] byte_en_n,
    input  logic             active_q,
    output cyc_e             kind,
    output logic             load,
    output logic             step,
    output logic             stop,
    output logic [BYTES-1:0] wmask
);

    logic             cpu_go;
    logic [BYTES-1:0] raw_mask;

    always_comb begin
        cpu_go   = !strb_cpu_n && !en1_n;
        raw_mask = !wr_all_n ? {BYTES{1'b1}} :
                   (!wr_bytes_n ? ~byte_en_n : {BYTES{1'b0}});
        kind = CYC_IDLE;
        load = 1'b0;
        step = 1'b0;
        stop = 1'b0;
        if (cpu_go) begin
            if (en2) begin
                kind = CYC_READ;
                load = 1'b1;
            end else begin
                stop = 1'b1;
            end
        end else if (!strb_ctl_n) begin
            if (!en1_n && en2) begin
                load = 1'b1;
                kind = (raw_mask != '0) ? CYC_WRITE : CYC_READ;
            end else begin
                stop = 1'b1;
            end
        end else if (active_q) begin
            step = !adv_n;
            kind = (raw_mask != '0) ? CYC_WRITE : CYC_READ;
        end
        wmask = (kind == CYC_WRITE) ? raw_mask : {BYTES{1'b0}};
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              il,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } burst_t;

    burst_t    st_q, st_d;
    logic [1:0] cnt_use;

    always_comb begin
        st_d     = st_q;
        cnt_use  = step ? st_q.cnt + 2'd1 : st_q.cnt;
        acc_addr = {st_q.base[ADDR_W-1:2], burst_low(st_q.base[1:0], cnt_use, il)};
        if (load) begin
            st_d.base = ext_addr;
            st_d.cnt  = 2'd0;
            acc_addr  = ext_addr;
        end else begin
            st_d.cnt = cnt_use;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic [BYTES-1:0]        wmask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [BYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wmask[g]) lane_q[waddr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane_q[raddr];
    end

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    en1_n,
    input  logic                    en2,
    input  logic                    wr_all_n,
    input  logic                    wr_bytes_n,
    input  logic [BYTES-1:0]        byte_en_n,
    input  logic                    burst_il,
    input  logic                    pipe_en,
    input  logic                    out_en_n,
    input  logic [BYTES*BYTE_W-1:0] din,
    output logic [BYTES*BYTE_W-1:0] dout,
    output logic                    dout_oe
);

    localparam int DW = BYTES * BYTE_W;

    typedef struct packed {
        logic              active;   // burst in progress
        logic              rd1;      // read taken at last edge
        logic              ft_on;    // flow-through driver state
        logic              was_idle; // last edge was a deselect/idle
        logic              wr;       // last edge was a write
        logic              pp_on;    // pipeline driver state
        logic [ADDR_W-1:0] rd_addr;
        logic [DW-1:0]     pp_data;
    } ctrl_t;

    ctrl_t             st_q, st_d;
    cyc_e              kind;
    logic              load, step, stop;
    logic [BYTES-1:0]  wmask;
    logic [ADDR_W-1:0] acc_addr;
    logic [DW-1:0]     arr_rdata;

    sbsram_decode #(.BYTES(BYTES)) u_dec (
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .en1_n      (en1_n),
        .en2        (en2),
        .wr_all_n   (wr_all_n),
        .wr_bytes_n (wr_bytes_n),
        .byte_en_n  (byte_en_n),
        .active_q   (st_q.active),
        .kind       (kind),
        .load       (load),
        .step       (step),
        .stop       (stop),
        .wmask      (wmask)
    );

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .il       (burst_il),
        .ext_addr (addr),
        .acc_addr (acc_addr)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
        .clk   (clk),
        .wmask (wmask),
        .waddr (acc_addr),
        .wdata (din),
        .raddr (st_q.rd_addr),
        .rdata (arr_rdata)
    );

    always_comb begin
        st_d          = st_q;
        st_d.active   = load ? 1'b1 : (stop ? 1'b0 : st_q.active);
        st_d.rd1      = (kind == CYC_READ);
        st_d.pp_on    = st_q.rd1;
        st_d.pp_data  = arr_rdata;
        st_d.wr       = (kind == CYC_WRITE);
        st_d.was_idle = (kind == CYC_IDLE);
        unique case (kind)
            CYC_READ: begin
                st_d.ft_on   = 1'b1;
                st_d.rd_addr = acc_addr;
            end
            CYC_WRITE: st_d.ft_on = 1'b0;
            default:   st_d.ft_on = st_q.was_idle ? 1'b0 : st_q.ft_on;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = pipe_en ? st_q.pp_data : arr_rdata;
    assign dout_oe = !out_en_n && !st_q.wr && (pipe_en ? st_q.pp_on : st_q.ft_on);

endmodule

module sbsram_chk #(
    parameter int BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strb_cpu_n,
    input logic             strb_ctl_n,
    input logic             en1_n,
    input logic             en2,
    input logic             wr_all_n,
    input logic             wr_bytes_n,
    input logic [BYTES-1:0] byte_en_n,
    input logic             out_en_n,
    input logic             pipe_en,
    input logic             dout_oe
);

    // R12
    oe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dout_oe);

    // R11
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && !en1_n && en2 &&
         (!wr_all_n || (!wr_bytes_n && (~byte_en_n != '0)))) |=> !dout_oe);

    // R10 R5
    dcd_en1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && !strb_ctl_n && en1_n) |=> ##1 (!pipe_en || !dout_oe));

    // R6
    dcd_en2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && !strb_ctl_n && !en1_n && !en2) |=> ##1 (!pipe_en || !dout_oe));

    // R8 R9
    ft_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en && !strb_cpu_n && !en1_n && en2) |=> (dout_oe || out_en_n || pipe_en));

endmodule

bind sbsram_ctrl sbsram_chk #(.BYTES(BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .en1_n      (en1_n),
    .en2        (en2),
    .wr_all_n   (wr_all_n),
    .wr_bytes_n (wr_bytes_n),
    .byte_en_n  (byte_en_n),
    .out_en_n   (out_en_n),
    .pipe_en    (pipe_en),
    .dout_oe    (dout_oe)
);

// File: tb/tb_sbsram_ctrl.sv
module tb_sbsram_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
    logic        en1_n = 1'b0, en2 = 1'b1;
    logic        wr_all_n = 1'b1, wr_bytes_n = 1'b1;
    logic [3:0]  byte_en_n = 4'hF;
    logic        burst_il = 1'b0, pipe_en = 1'b0, out_en_n = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dout_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sbsram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .en1_n(en1_n), .en2(en2), .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n),
        .byte_en_n(byte_en_n), .burst_il(burst_il), .pipe_en(pipe_en),
        .out_en_n(out_en_n), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [31:0] pat(input logic [7:0] a);
        return {8'hC3, a, ~a, 8'h5A};
    endfunction

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
        en1_n = 1'b0; en2 = 1'b1;
        wr_all_n = 1'b1; wr_bytes_n = 1'b1; byte_en_n = 4'hF;
    endtask

    task automatic desel();
        quiet();
        strb_ctl_n = 1'b0; en1_n = 1'b1;
        tick();
        quiet();
        tick();
    endtask

    task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
        quiet();
        strb_ctl_n = 1'b0; wr_all_n = 1'b0; addr = a; din = d;
        tick();
        chk1("R11 write keeps drivers off", dout_oe, 1'b0);
    endtask

    task automatic ctl_read(input logic [7:0] a);
        quiet();
        strb_ctl_n = 1'b0; addr = a;
        tick();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk1("R10 reset drivers off", dout_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 4; i++) wr_word(8'h10 + 8'(i), pat(8'h10 + 8'(i)));
        for (int i = 0; i < 4; i++) wr_word(8'h24 + 8'(i), pat(8'h24 + 8'(i)));
        desel();
    endtask

    task automatic t_burst(input logic [7:0] s, input logic il, input string tag);
        logic [1:0] lo;
        burst_il = il;
        ctl_read(s);
        chk32({tag, " first"}, dout, pat(s));
        for (int i = 1; i <= 4; i++) begin
            quiet();
            adv_n = 1'b0;
            tick();
            lo = il ? (s[1:0] ^ 2'(i)) : (s[1:0] + 2'(i));
            if (i == 4) chk32("R3 wrap to start", dout, pat(s));
            else        chk32(tag, dout, pat({s[7:2], lo}));
        end
        burst_il = 1'b0;
        desel();
    endtask

    task automatic t_suspend();
        ctl_read(8'h11);
        quiet(); adv_n = 1'b0; tick();
        chk32("R4 step before suspend", dout, pat(8'h12));
        quiet(); adv_n = 1'b1; tick();
        chk32("R4 suspend holds address", dout, pat(8'h12));
        quiet(); adv_n = 1'b0; tick();
        chk32("R4 resume after suspend", dout, pat(8'h13));
        desel();
    endtask

    task automatic t_bytes();
        wr_word(8'h30, 32'h1122_3344);
        quiet();
        strb_ctl_n = 1'b0; wr_bytes_n = 1'b0; byte_en_n = 4'b1010;
        addr = 8'h30; din = 32'hAABB_CCDD;
        tick();
        chk1("R11 byte write drivers off", dout_oe, 1'b0);
        quiet();
        strb_ctl_n = 1'b0; wr_bytes_n = 1'b0; byte_en_n = 4'hF;
        addr = 8'h30; din = 32'h0;
        tick();
        chk1("R7 no byte enable is a read", dout_oe, 1'b1);
        chk32("R7 only enabled bytes written", dout, 32'h11BB_33DD);
        desel();
    endtask

    task automatic t_cpu_read();
        quiet();
        strb_cpu_n = 1'b0; wr_all_n = 1'b0; addr = 8'h30; din = 32'h0;
        tick();
        chk32("R8 processor cycle reads", dout, 32'h11BB_33DD);
        desel();
        ctl_read(8'h30);
        chk32("R8 processor cycle did not write", dout, 32'h11BB_33DD);
        desel();
    endtask

    task automatic t_en2();
        quiet();
        strb_ctl_n = 1'b0; en2 = 1'b0; wr_all_n = 1'b0; addr = 8'h30; din = 32'h0;
        tick();
        quiet(); tick();
        ctl_read(8'h30);
        chk32("R6 en2 low blocks write", dout, 32'h11BB_33DD);
        desel();
    endtask

    task automatic t_en1();
        ctl_read(8'h24);
        quiet();
        strb_cpu_n = 1'b0; en1_n = 1'b1; adv_n = 1'b0; addr = 8'h10;
        tick();
        chk32("R5 blocked processor strobe continues burst", dout, pat(8'h25));
        quiet();
        strb_ctl_n = 1'b0; en1_n = 1'b1;
        tick();
        chk1("R10 flow-through held one cycle after deselect", dout_oe, 1'b1);
        chk32("R10 held data", dout, pat(8'h25));
        quiet();
        tick();
        chk1("R5 controller strobe with en1 high deselects", dout_oe, 1'b0);
    endtask

    task automatic t_dummy();
        out_en_n = 1'b1;
        ctl_read(8'h10);
        chk1("R12 output enable high forces off", dout_oe, 1'b0);
        quiet(); adv_n = 1'b0; tick();
        out_en_n = 1'b0;
        quiet(); adv_n = 1'b0; tick();
        chk32("R12 dummy reads advanced counter", dout, pat(8'h12));
        #2 out_en_n = 1'b1;
        #1 chk1("R12 asynchronous turn-off", dout_oe, 1'b0);
        out_en_n = 1'b0;
        #1 chk1("R12 asynchronous turn-on", dout_oe, 1'b1);
        @(negedge clk);
        desel();
    endtask

    task automatic t_pipe();
        pipe_en = 1'b1;
        ctl_read(8'h13);
        chk1("R9 pipeline not yet driving", dout_oe, 1'b0);
        quiet();
        strb_ctl_n = 1'b0; en1_n = 1'b1;
        tick();
        chk1("R9 pipeline drives one edge later", dout_oe, 1'b1);
        chk32("R9 pipeline data", dout, pat(8'h13));
        quiet();
        tick();
        chk1("R10 pipeline off after second edge", dout_oe, 1'b0);
        tick();
        pipe_en = 1'b0;
        tick();
    endtask

    task automatic t_read_write();
        ctl_read(8'h10);
        chk1("R9 flow-through drives at once", dout_oe, 1'b1);
        wr_word(8'h13, pat(8'h13));
        desel();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill();
        t_burst(8'h12, 1'b0, "R1 linear order");
        t_burst(8'h25, 1'b1, "R2 interleaved order");
        t_suspend();
        t_bytes();
        t_cpu_read();
        t_en2();
        t_en1();
        t_dummy();
        t_pipe();
        t_read_write();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule